// File: doc/BRIEF.md
# Banked Serial Channel Register Window

This block lets a host reach up to 32 serial channels, spread over four boards of eight channels each, through a window of only eight byte-wide registers. The host first writes a select register that names a board and a channel on it. Later data and status accesses in the window are forwarded on a downstream channel bus to the registers of that channel. Mode and command writes are forwarded the same way. Two more offsets give the host a per-board view of which channels have a received character waiting and which can take another character to send. They also hold a mask for each of those two sets.

Each board has an installed flag. While the selected board is not installed, the window behaves as an empty slot: reads return all ones and writes are discarded, with one exception. The select register can always be written, so the host can move away from a missing board. Two interrupt outputs, one for receive and one for transmit, combine the masked status of every installed board. The serial engines sit behind the downstream bus and are not part of this block.

Top module: `uart_bank_window`

## Requirements
- R1: The low three host address bits pick the function: 0 channel data, 1 channel status, 2 mode, 3 command, 4 transmit status (read) or transmit mask (write), 5 receive status (read) or receive mask (write), 6 reserved, 7 select.
- R2: A write to offset 7 loads the board number from write data bits [4:3] and the channel number from bits [2:0], and ignores bits [7:5]. It takes effect even when the selected board is not installed.
- R3: A host read of offset 0 or 1 raises dn_rd in the same cycle. dn_addr is board*16 + channel*2 for data and that value + 1 for status, and dn_kind is 0 for data and 1 for status.
- R4: host_rdata shows, one clock after a read strobe, the value that the read selected in the strobe cycle. For offsets 0 and 1 that value is dn_rdata. host_rdata keeps its value while no read is made.
- R5: Reads of offsets 2, 3, 6 and 7 return 0xFF and make no downstream access.
- R6: While the selected board's installed flag is low, every read returns 0xFF and every write other than to offset 7 is dropped: no downstream strobe and no mask change.
- R7: A write to offset 4 loads the selected board's transmit mask. A read of offset 4 returns that board's transmit status, where bit i is ch_tx_empty of channel i of the board (flat index board*8 + i).
- R8: A write to offset 5 loads the selected board's receive mask. A read of offset 5 returns that board's receive status, where bit i is ch_rx_ready of channel i of the board.
- R9: Each board keeps its own two masks. Loading a mask of one board leaves the masks of all other boards unchanged.
- R10: tx_irq (rx_irq) is high in the same cycle whenever any installed board has a channel whose transmit (receive) status bit and mask bit are both set.
- R11: After reset the board and channel selects and all masks are zero and host_rdata is 0xFF.
- R12: Writes to offsets 1 and 6 make no downstream access and change no state.
- R13: Writes to offsets 0, 2 and 3 raise dn_wr in the same cycle, with dn_kind 0, 2 or 3 respectively, dn_wdata equal to the host data and dn_addr equal to the channel's data address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 3 | Window offset |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| board_present | input | 4 | Installed flag per board |
| ch_tx_empty | input | 32 | Per-channel transmit-ready flag, board-major |
| ch_rx_ready | input | 32 | Per-channel received-character flag, board-major |
| dn_rd | output | 1 | Downstream read strobe |
| dn_wr | output | 1 | Downstream write strobe |
| dn_kind | output | 2 | Downstream register kind: 0 data, 1 status, 2 mode, 3 command |
| dn_addr | output | 6 | Downstream channel register address |
| dn_wdata | output | 8 | Downstream write data |
| dn_rdata | input | 8 | Downstream read data, valid in the strobe cycle |
| tx_irq | output | 1 | Masked transmit interrupt over installed boards |
| rx_irq | output | 1 | Masked receive interrupt over installed boards |

## Verification
If the select register holds a wrong board or channel, the very next data or status access shows it: dn_addr comes out wrong in the strobe cycle itself. A wrong board also shows up one cycle later as a status read of a different byte, or as 0xFF from an installed board. A mask written into the wrong board shows on tx_irq or rx_irq as soon as the status inputs of the affected boards differ, so the bench loads masks one board at a time and moves the status around. Gating faults for missing boards show as a downstream strobe in the access cycle, or as a mask that takes effect once the board is marked installed.

// File: rtl/ubw_pkg.sv
package ubw_pkg;

    typedef enum logic [2:0] {
        OFS_DATA = 3'd0,
        OFS_STAT = 3'd1,
        OFS_MODE = 3'd2,
        OFS_CMD  = 3'd3,
        OFS_TXIR = 3'd4,
        OFS_RXIR = 3'd5,
        OFS_RSVD = 3'd6,
        OFS_SEL  = 3'd7
    } win_ofs_e;

    typedef enum logic [1:0] {
        KIND_DATA = 2'd0,
        KIND_STAT = 2'd1,
        KIND_MODE = 2'd2,
        KIND_CMD  = 2'd3
    } ch_kind_e;

    typedef enum logic [2:0] {
        RSRC_IDLE = 3'd0,
        RSRC_CHAN = 3'd1,
        RSRC_TX   = 3'd2,
        RSRC_RX   = 3'd3,
        RSRC_ONES = 3'd4
    } rd_src_e;

    typedef struct packed {
        logic     dn_rd;
        logic     dn_wr;
        ch_kind_e kind;
        logic     sel_we;
        logic     txm_we;
        logic     rxm_we;
        rd_src_e  rsrc;
    } win_op_t;

endpackage

// File: rtl/ubw_decode.sv
module ubw_decode
    import ubw_pkg::*;
(
    input  logic [2:0] addr,
    input  logic       rd,
    input  logic       wr,
    input  logic       sel_present,
    output win_op_t    op
);
    always_comb begin
        op      = '0;
        op.kind = KIND_DATA;
        op.rsrc = RSRC_IDLE;
        if (wr) begin
            if (win_ofs_e'(addr) == OFS_SEL) begin
                op.sel_we = 1'b1;
            end else if (sel_present) begin
                case (win_ofs_e'(addr))
                    OFS_DATA: begin op.dn_wr = 1'b1; op.kind = KIND_DATA; end
                    OFS_MODE: begin op.dn_wr = 1'b1; op.kind = KIND_MODE; end
                    OFS_CMD:  begin op.dn_wr = 1'b1; op.kind = KIND_CMD;  end
                    OFS_TXIR: op.txm_we = 1'b1;
                    OFS_RXIR: op.rxm_we = 1'b1;
                    default:  ;
                endcase
            end
        end
        if (rd) begin
            if (!sel_present) begin
                op.rsrc = RSRC_ONES;
            end else begin
                case (win_ofs_e'(addr))
                    OFS_DATA: begin op.dn_rd = 1'b1; op.kind = KIND_DATA; op.rsrc = RSRC_CHAN; end
                    OFS_STAT: begin op.dn_rd = 1'b1; op.kind = KIND_STAT; op.rsrc = RSRC_CHAN; end
                    OFS_TXIR: op.rsrc = RSRC_TX;
                    OFS_RXIR: op.rsrc = RSRC_RX;
                    default:  op.rsrc = RSRC_ONES;
                endcase
            end
        end
    end
endmodule

// File: rtl/ubw_mask_bank.sv
module ubw_mask_bank #(
    parameter int NUM_BOARDS   = 4,
    parameter int CH_PER_BOARD = 8,
    localparam int BW = $clog2(NUM_BOARDS),
    localparam int NCH = NUM_BOARDS * CH_PER_BOARD
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [BW-1:0]           sel_board,
    input  logic [CH_PER_BOARD-1:0] wdata,
    input  logic                    txm_we,
    input  logic                    rxm_we,
    output logic [NCH-1:0]          tx_mask,
    output logic [NCH-1:0]          rx_mask
);
    logic [CH_PER_BOARD-1:0] txm_q [NUM_BOARDS];
    logic [CH_PER_BOARD-1:0] rxm_q [NUM_BOARDS];

    for (genvar b = 0; b < NUM_BOARDS; b++) begin : g_board
        logic hit;
        assign hit = (sel_board == BW'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                txm_q[b] <= '0;
                rxm_q[b] <= '0;
            end else begin
                if (txm_we && hit) txm_q[b] <= wdata;
                if (rxm_we && hit) rxm_q[b] <= wdata;
            end
        end

        assign tx_mask[b*CH_PER_BOARD +: CH_PER_BOARD] = txm_q[b];
        assign rx_mask[b*CH_PER_BOARD +: CH_PER_BOARD] = rxm_q[b];
    end
endmodule

// File: rtl/ubw_irq_reduce.sv
module ubw_irq_reduce #(
    parameter int NUM_BOARDS   = 4,
    parameter int CH_PER_BOARD = 8,
    localparam int NCH = NUM_BOARDS * CH_PER_BOARD
) (
    input  logic [NUM_BOARDS-1:0] present,
    input  logic [NCH-1:0]        tx_stat,
    input  logic [NCH-1:0]        rx_stat,
    input  logic [NCH-1:0]        tx_mask,
    input  logic [NCH-1:0]        rx_mask,
    output logic                  tx_irq,
    output logic                  rx_irq
);
    logic [NUM_BOARDS-1:0] tx_pend;
    logic [NUM_BOARDS-1:0] rx_pend;

    for (genvar b = 0; b < NUM_BOARDS; b++) begin : g_pend
        localparam int LO = b * CH_PER_BOARD;
        assign tx_pend[b] = present[b] &
            (|(tx_stat[LO +: CH_PER_BOARD] & tx_mask[LO +: CH_PER_BOARD]));
        assign rx_pend[b] = present[b] &
            (|(rx_stat[LO +: CH_PER_BOARD] & rx_mask[LO +: CH_PER_BOARD]));
    end

    assign tx_irq = |tx_pend;
    assign rx_irq = |rx_pend;
endmodule

// File: rtl/uart_bank_window.sv
module uart_bank_window
    import ubw_pkg::*;
#(
    parameter int NUM_BOARDS   = 4,
    parameter int CH_PER_BOARD = 8,
    parameter int DATA_W       = 8,
    parameter int BOARD_STRIDE = 16
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic [2:0]                             host_addr,
    input  logic                                   host_rd,
    input  logic                                   host_wr,
    input  logic [DATA_W-1:0]                      host_wdata,
    output logic [DATA_W-1:0]                      host_rdata,
    input  logic [NUM_BOARDS-1:0]                  board_present,
    input  logic [NUM_BOARDS*CH_PER_BOARD-1:0]     ch_tx_empty,
    input  logic [NUM_BOARDS*CH_PER_BOARD-1:0]     ch_rx_ready,
    output logic                                   dn_rd,
    output logic                                   dn_wr,
    output logic [1:0]                             dn_kind,
    output logic [$clog2(NUM_BOARDS*BOARD_STRIDE)-1:0] dn_addr,
    output logic [DATA_W-1:0]                      dn_wdata,
    input  logic [DATA_W-1:0]                      dn_rdata,
    output logic                                   tx_irq,
    output logic                                   rx_irq
);
    localparam int BW  = $clog2(NUM_BOARDS);
    localparam int CW  = $clog2(CH_PER_BOARD);
    localparam int AW  = $clog2(NUM_BOARDS*BOARD_STRIDE);
    localparam int NCH = NUM_BOARDS * CH_PER_BOARD;

    logic [BW-1:0] sel_board;
    logic [CW-1:0] sel_chan;
    logic          sel_present;
    win_op_t       op;
    logic [NCH-1:0] tx_mask;
    logic [NCH-1:0] rx_mask;
    logic [CH_PER_BOARD-1:0] tx_slice;
    logic [CH_PER_BOARD-1:0] rx_slice;

    assign sel_present = board_present[sel_board];

    ubw_decode u_dec (
        .addr        (host_addr),
        .rd          (host_rd),
        .wr          (host_wr),
        .sel_present (sel_present),
        .op          (op)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_board <= '0;
            sel_chan  <= '0;
        end else if (op.sel_we) begin
            sel_chan  <= host_wdata[CW-1:0];
            sel_board <= host_wdata[CW+BW-1:CW];
        end
    end

    ubw_mask_bank #(
        .NUM_BOARDS   (NUM_BOARDS),
        .CH_PER_BOARD (CH_PER_BOARD)
    ) u_masks (
        .clk       (clk),
        .rst       (rst),
        .sel_board (sel_board),
        .wdata     (host_wdata[CH_PER_BOARD-1:0]),
        .txm_we    (op.txm_we),
        .rxm_we    (op.rxm_we),
        .tx_mask   (tx_mask),
        .rx_mask   (rx_mask)
    );

    ubw_irq_reduce #(
        .NUM_BOARDS   (NUM_BOARDS),
        .CH_PER_BOARD (CH_PER_BOARD)
    ) u_irq (
        .present (board_present),
        .tx_stat (ch_tx_empty),
        .rx_stat (ch_rx_ready),
        .tx_mask (tx_mask),
        .rx_mask (rx_mask),
        .tx_irq  (tx_irq),
        .rx_irq  (rx_irq)
    );

    // Downstream channel bus, issued in the host strobe cycle.
    assign dn_rd    = op.dn_rd;
    assign dn_wr    = op.dn_wr;
    assign dn_kind  = op.kind;
    assign dn_wdata = host_wdata;
    assign dn_addr  = AW'(int'(sel_board) * BOARD_STRIDE + int'(sel_chan) * 2
                          + ((op.kind == KIND_STAT) ? 1 : 0));

    assign tx_slice = ch_tx_empty[sel_board*CH_PER_BOARD +: CH_PER_BOARD];
    assign rx_slice = ch_rx_ready[sel_board*CH_PER_BOARD +: CH_PER_BOARD];

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rdata <= '1;
        end else begin
            case (op.rsrc)
                RSRC_CHAN: host_rdata <= dn_rdata;
                RSRC_TX:   host_rdata <= DATA_W'(tx_slice);
                RSRC_RX:   host_rdata <= DATA_W'(rx_slice);
                RSRC_ONES: host_rdata <= '1;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/ubw_checks.sv
module ubw_checks #(
    parameter int NUM_BOARDS   = 4,
    parameter int CH_PER_BOARD = 8,
    parameter int DATA_W       = 8,
    parameter int AW           = 6,
    localparam int BW = $clog2(NUM_BOARDS),
    localparam int CW = $clog2(CH_PER_BOARD)
) (
    input logic                  clk,
    input logic                  rst,
    input logic [2:0]            host_addr,
    input logic                  host_rd,
    input logic                  host_wr,
    input logic [DATA_W-1:0]     host_wdata,
    input logic [DATA_W-1:0]     host_rdata,
    input logic [NUM_BOARDS-1:0] board_present,
    input logic [BW-1:0]         sel_board,
    input logic [CW-1:0]         sel_chan,
    input logic                  dn_rd,
    input logic                  dn_wr,
    input logic [1:0]            dn_kind,
    input logic [AW-1:0]         dn_addr,
    input logic [DATA_W-1:0]     dn_rdata
);
    a_r6_absent_no_dn: assert property (@(posedge clk) disable iff (rst)
        !board_present[sel_board] |-> (!dn_rd && !dn_wr));

    a_r6_absent_read_ones: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !board_present[sel_board]) |=> (host_rdata == '1));

    a_r2_select_load: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == 3'd7) |=>
        (sel_chan == $past(host_wdata[CW-1:0]) &&
         sel_board == $past(host_wdata[CW+BW-1:CW])));

    a_r5_unsup_ones: assert property (@(posedge clk) disable iff (rst)
        (host_rd && (host_addr == 3'd2 || host_addr == 3'd3 ||
                     host_addr == 3'd6 || host_addr == 3'd7)) |=> (host_rdata == '1));

    a_r5_unsup_no_dn: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !host_wr && (host_addr == 3'd2 || host_addr == 3'd3 ||
                     host_addr == 3'd6 || host_addr == 3'd7)) |-> !dn_rd);

    a_r4_chan_return: assert property (@(posedge clk) disable iff (rst)
        dn_rd |=> (host_rdata == $past(dn_rdata)));

    a_r3_status_odd: assert property (@(posedge clk) disable iff (rst)
        (dn_rd || dn_wr) |-> (dn_addr[0] == (dn_kind == 2'd1)));

    a_r11_reset_clear: assert property (@(posedge clk)
        rst |=> (sel_board == '0 && sel_chan == '0 && host_rdata == '1));
endmodule

bind uart_bank_window ubw_checks #(
    .NUM_BOARDS   (NUM_BOARDS),
    .CH_PER_BOARD (CH_PER_BOARD),
    .DATA_W       (DATA_W),
    .AW           (AW)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .host_addr     (host_addr),
    .host_rd       (host_rd),
    .host_wr       (host_wr),
    .host_wdata    (host_wdata),
    .host_rdata    (host_rdata),
    .board_present (board_present),
    .sel_board     (sel_board),
    .sel_chan      (sel_chan),
    .dn_rd         (dn_rd),
    .dn_wr         (dn_wr),
    .dn_kind       (dn_kind),
    .dn_addr       (dn_addr),
    .dn_rdata      (dn_rdata)
);

// File: tb/uart_bank_window_tb.sv
module uart_bank_window_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  host_addr = '0;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [3:0]  board_present = 4'b1111;
    logic [31:0] ch_tx_empty = '0;
    logic [31:0] ch_rx_ready = '0;
    logic        dn_rd, dn_wr;
    logic [1:0]  dn_kind;
    logic [5:0]  dn_addr;
    logic [7:0]  dn_wdata;
    logic [7:0]  dn_rdata;
    logic        tx_irq, rx_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    // Downstream responder: a fixed function of the address.
    assign dn_rdata = dn_rd ? (8'h5A ^ {2'b00, dn_addr}) : 8'h00;

    uart_bank_window u_dut (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_rd(host_rd),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .board_present(board_present), .ch_tx_empty(ch_tx_empty),
        .ch_rx_ready(ch_rx_ready), .dn_rd(dn_rd), .dn_wr(dn_wr),
        .dn_kind(dn_kind), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
        .dn_rdata(dn_rdata), .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Host read: captures downstream signals in the strobe cycle, data after the edge.
    task automatic host_read(input logic [2:0] a, output logic [7:0] d,
                             output logic seen_rd, output logic seen_wr,
                             output logic [5:0] seen_addr, output logic [1:0] seen_kind);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1;
        seen_rd = dn_rd; seen_wr = dn_wr; seen_addr = dn_addr; seen_kind = dn_kind;
        @(posedge clk);
        #1;
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic host_write(input logic [2:0] a, input logic [7:0] v,
                              output logic seen_wr, output logic seen_rd,
                              output logic [5:0] seen_addr, output logic [1:0] seen_kind,
                              output logic [7:0] seen_wdata);
        @(negedge clk);
        host_addr = a; host_wr = 1'b1; host_wdata = v;
        #1;
        seen_wr = dn_wr; seen_rd = dn_rd; seen_addr = dn_addr;
        seen_kind = dn_kind; seen_wdata = dn_wdata;
        @(posedge clk);
        #1;
        host_wr = 1'b0;
    endtask

    task automatic select(input int b, input int c);
        logic w, r; logic [5:0] a; logic [1:0] k; logic [7:0] d;
        host_write(3'd7, 8'((b << 3) | c), w, r, a, k, d);
    endtask

    task automatic t_reset;
        logic [7:0] d; logic r, w; logic [5:0] a; logic [1:0] k;
        check(host_rdata == 8'hFF, "R11 rdata after reset", host_rdata, 8'hFF);
        ch_tx_empty = '1; ch_rx_ready = '1;
        #1;
        check(!tx_irq && !rx_irq, "R11 masks clear, irq low", {tx_irq, rx_irq}, 0);
        ch_tx_empty = '0; ch_rx_ready = '0;
        host_read(3'd0, d, r, w, a, k);
        check(r && a == 6'd0, "R11 select zero after reset", a, 0);
    endtask

    task automatic t_data_status;
        logic [7:0] d; logic r, w; logic [5:0] a; logic [1:0] k;
        int pairs [4][2] = '{'{0, 0}, '{1, 3}, '{2, 6}, '{3, 7}};
        foreach (pairs[i]) begin
            int b = pairs[i][0];
            int c = pairs[i][1];
            int ea = b * 16 + c * 2;
            select(b, c);
            host_read(3'd0, d, r, w, a, k);
            check(r && !w && a == 6'(ea) && k == 2'd0, "R3 data address/kind", a, ea);
            check(d == (8'h5A ^ 8'(ea)), "R4 data returned", d, 8'h5A ^ 8'(ea));
            host_read(3'd1, d, r, w, a, k);
            check(r && a == 6'(ea + 1) && k == 2'd1, "R3 status address/kind", a, ea + 1);
            check(d == (8'h5A ^ 8'(ea + 1)), "R4 status returned", d, 8'h5A ^ 8'(ea + 1));
        end
        // R2: upper bits ignored: 0xE5 selects board 0 channel 5.
        begin
            logic ww, rr; logic [5:0] aa; logic [1:0] kk; logic [7:0] dd;
            host_write(3'd7, 8'hE5, ww, rr, aa, kk, dd);
        end
        host_read(3'd0, d, r, w, a, k);
        check(a == 6'd10, "R2 upper select bits ignored", a, 10);
        // R4: rdata holds with no read.
        repeat (3) @(posedge clk);
        #1;
        check(host_rdata == (8'h5A ^ 8'd10), "R4 rdata held", host_rdata, 8'h5A ^ 8'd10);
    endtask

    task automatic t_passthrough;
        logic r, w; logic [5:0] a; logic [1:0] k; logic [7:0] d;
        select(2, 4);
        host_write(3'd0, 8'h3C, w, r, a, k, d);
        check(w && !r && k == 2'd0 && a == 6'd40 && d == 8'h3C, "R13 data write", {k, a}, 40);
        host_write(3'd2, 8'h4E, w, r, a, k, d);
        check(w && k == 2'd2 && a == 6'd40 && d == 8'h4E, "R13 mode write", {k, a}, {2'd2, 6'd40});
        host_write(3'd3, 8'h27, w, r, a, k, d);
        check(w && k == 2'd3 && a == 6'd40 && d == 8'h27, "R13 command write", {k, a}, {2'd3, 6'd40});
        host_write(3'd1, 8'h11, w, r, a, k, d);
        check(!w && !r, "R12 status write no access", w, 0);
        host_write(3'd6, 8'h22, w, r, a, k, d);
        check(!w && !r, "R12 reserved write no access", w, 0);
        host_read(3'd0, d, r, w, a, k);
        check(a == 6'd40, "R12 select unchanged by reserved write", a, 40);
    endtask

    task automatic t_unsupported;
        logic [7:0] d; logic r, w; logic [5:0] a; logic [1:0] k;
        logic [2:0] ofs [4] = '{3'd2, 3'd3, 3'd6, 3'd7};
        select(1, 1);
        foreach (ofs[i]) begin
            host_read(ofs[i], d, r, w, a, k);
            check(d == 8'hFF && !r, "R5 unsupported read", {r, d}, 8'hFF);
        end
        // R1: offset 4 and 5 reads give status, not 0xFF.
        ch_tx_empty = 32'h0000_A500; ch_rx_ready = 32'h0000_3C00;
        host_read(3'd4, d, r, w, a, k);
        check(d == 8'hA5 && !r, "R1 R7 tx status read", d, 8'hA5);
        host_read(3'd5, d, r, w, a, k);
        check(d == 8'h3C && !r, "R1 R8 rx status read", d, 8'h3C);
        ch_tx_empty = '0; ch_rx_ready = '0;
    endtask

    task automatic t_masks;
        logic r, w; logic [5:0] a; logic [1:0] k; logic [7:0] d;
        select(1, 0);
        host_write(3'd4, 8'h04, w, r, a, k, d);
        host_write(3'd5, 8'h80, w, r, a, k, d);
        ch_tx_empty = 32'h0000_0400;
        #1;
        check(tx_irq, "R7 R10 tx mask on board 1", tx_irq, 1);
        ch_tx_empty = 32'h0000_0800;
        #1;
        check(!tx_irq, "R10 unmasked channel no irq", tx_irq, 0);
        ch_rx_ready = 32'h0000_8000;
        #1;
        check(rx_irq, "R8 R10 rx mask on board 1", rx_irq, 1);
        // R9: board 2 masks written; board 1 masks must stay.
        select(2, 0);
        host_write(3'd4, 8'h01, w, r, a, k, d);
        host_write(3'd5, 8'h00, w, r, a, k, d);
        ch_tx_empty = 32'h0000_0400; ch_rx_ready = 32'h0000_8000;
        #1;
        check(tx_irq && rx_irq, "R9 board 1 masks kept", {tx_irq, rx_irq}, 3);
        ch_tx_empty = 32'h0001_0000; ch_rx_ready = 32'h0080_0000;
        #1;
        check(tx_irq && !rx_irq, "R9 board 2 masks own", {tx_irq, rx_irq}, 2);
        // R10: uninstalled board does not raise irq.
        board_present = 4'b1011;
        #1;
        check(!tx_irq, "R10 irq gated by installed", tx_irq, 0);
        board_present = 4'b1111;
        ch_tx_empty = '0; ch_rx_ready = '0;
    endtask

    task automatic t_absent;
        logic r, w; logic [5:0] a; logic [1:0] k; logic [7:0] d;
        board_present = 4'b0111;
        select(3, 2);
        host_read(3'd0, d, r, w, a, k);
        check(d == 8'hFF && !r, "R6 absent data read", {r, d}, 8'hFF);
        ch_tx_empty = 32'h1200_0000;
        host_read(3'd4, d, r, w, a, k);
        check(d == 8'hFF, "R6 absent status read", d, 8'hFF);
        host_write(3'd0, 8'h55, w, r, a, k, d);
        check(!w && !r, "R6 absent data write dropped", w, 0);
        host_write(3'd4, 8'hFF, w, r, a, k, d);
        board_present = 4'b1111;
        ch_tx_empty = 32'hFF00_0000;
        #1;
        check(!tx_irq, "R6 absent mask write dropped", tx_irq, 0);
        ch_tx_empty = '0;
        // R2: select works while the board is missing.
        board_present = 4'b0111;
        select(0, 3);
        host_read(3'd1, d, r, w, a, k);
        check(r && a == 6'd7, "R2 select while absent", a, 7);
        board_present = 4'b1111;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_data_status();
        t_passthrough();
        t_unsupported();
        t_masks();
        t_absent();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule